// File: doc/BRIEF.md
# I2C Register-Mapped Control Slave

This block is a slave on a two-wire I2C-compatible bus. It lets a host read and write a bank of 8-bit control registers that live outside the block. It oversamples SCL and SDA with a fast system clock and recognises START, repeated START and STOP. It matches a fixed 7-bit device address and pulls SDA low (open-drain) to acknowledge bytes and to send read data.

A write transaction has three bytes: the address byte, then a register index, then the data for that register. The block does not act on the register as soon as the data byte arrives. It commits the write with a one-cycle strobe at the rising SCL edge of its own acknowledge for the data byte. A read first writes the index. A repeated START then follows with the direction bit set. The block then returns the value that the surrounding logic presents on the read-data input for the stored index. It sends bytes for as long as the host acknowledges them.

Top module: `i2c_reg_slave`

## Requirements
- R1: A START or repeated START (SDA falling while SCL is high) restarts address reception from any state. A STOP (SDA rising while SCL is high) returns the block to idle. `bus_busy` is 1 from a START until the next STOP, and SDA is released while idle.
- R2: The address byte is seven address bits, MSB first, followed by a direction bit (0 = write, 1 = read). When the seven bits equal 0011010, the block holds SDA low throughout the ninth clock.
- R3: On any other address the block does not acknowledge. It keeps SDA released, writes nothing and ignores all bytes until the next START or STOP.
- R4: In a write, the block acknowledges the byte after the address as the register index and shows it on `reg_idx` once that byte is complete. The index is kept across a repeated START and across a STOP.
- R5: The byte after the index is the data. `reg_wr_stb` is a single-cycle pulse, with `reg_idx`/`reg_wdata` valid, raised at the SCL rising edge of the ninth clock of the data byte and never before it.
- R6: Within one write transaction, bytes after the data byte are not acknowledged and cause no further strobe.
- R7: After a repeated START with the matching address and direction bit 1, the block sends the value of `reg_rdata`, MSB first, for the stored index. `reg_rdata` is sampled at the rising SCL edge of the address acknowledge.
- R8: During a read, the block samples the host's ninth bit. An acknowledge (0) makes it send another byte, sampled again from `reg_rdata`. A not-acknowledge (1) makes it release SDA and wait for a STOP or START.
- R9: The block changes its SDA drive only while SCL is low. Each change comes at least HOLD_CYC system clocks after the synchronised SCL falling edge, which sets the output hold time.
- R10: After reset, SDA is released, `reg_wr_stb` and `bus_busy` are 0, and `reg_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| bus_busy | output | 1 | High between START and STOP |
| reg_wr_stb | output | 1 | One-cycle register write strobe |
| reg_idx | output | 8 | Current register index |
| reg_wdata | output | 8 | Data for the register write |
| reg_rdata | input | 8 | Read data for `reg_idx`, supplied by the register bank |

## Verification
The assertions rely on two assumptions about the inputs. SCL stays low long enough for the two-stage synchroniser, the edge detector and the HOLD_CYC delay to settle the SDA drive before SCL rises again. The host also changes SDA only after the synchronised SCL has gone low, so no data transition is mistaken for a START or STOP. The bench keeps to both: one SCL period is twenty system clocks, with twelve of them low. Every SDA change by the host comes four clocks after SCL falls, and SCL rises eight clocks after that. Before a STOP the host always sends a not-acknowledge for the last read byte, so the slave never holds SDA against the STOP.

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'b0011010,
  parameter int         HOLD_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       bus_busy,
  output logic       reg_wr_stb,
  output logic [7:0] reg_idx,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata
);

  localparam int HW = $clog2(HOLD_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_IDX, S_WD, S_RD, S_IGN} state_t;

  state_t      state;
  logic [1:0]  scl_sync, sda_sync;
  logic        scl_q, sda_q;
  logic [3:0]  bit_cnt;
  logic [7:0]  shreg, txreg;
  logic        rw_bit, addr_hit;
  logic        pend, pend_oe;
  logic [HW-1:0] hold_cnt;

  wire scl_s     = scl_sync[1];
  wire sda_s     = sda_sync[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire active    = (state == S_ADDR) || (state == S_IDX) || (state == S_WD) || (state == S_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      txreg      <= '0;
      rw_bit     <= 1'b0;
      addr_hit   <= 1'b0;
      pend       <= 1'b0;
      pend_oe    <= 1'b0;
      hold_cnt   <= '0;
      sda_oe     <= 1'b0;
      bus_busy   <= 1'b0;
      reg_wr_stb <= 1'b0;
      reg_idx    <= '0;
      reg_wdata  <= '0;
    end else begin
      reg_wr_stb <= 1'b0;
      if (pend) begin
        if (hold_cnt == '0) begin
          sda_oe <= pend_oe;
          pend   <= 1'b0;
        end else begin
          hold_cnt <= hold_cnt - 1'b1;
        end
      end

      if (start_det) begin
        state    <= S_ADDR;
        bit_cnt  <= '0;
        addr_hit <= 1'b0;
        bus_busy <= 1'b1;
        pend     <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_det) begin
        state    <= S_IDLE;
        bit_cnt  <= '0;
        bus_busy <= 1'b0;
        pend     <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (scl_rise && active) begin
        if (bit_cnt != 4'd8) begin
          shreg   <= {shreg[6:0], sda_s};
          bit_cnt <= bit_cnt + 1'b1;
        end else begin
          bit_cnt <= '0;
          case (state)
            S_ADDR: begin
              if (addr_hit) begin
                state <= rw_bit ? S_RD : S_IDX;
                if (rw_bit) txreg <= reg_rdata;
              end
            end
            S_IDX: state <= S_WD;
            S_WD: begin
              reg_wr_stb <= 1'b1;
              state      <= S_IGN;
            end
            S_RD: begin
              if (!sda_s) txreg <= reg_rdata;
              else        state <= S_IGN;
            end
            default: state <= S_IGN;
          endcase
        end
      end else if (scl_fall) begin
        pend     <= 1'b1;
        hold_cnt <= HW'(HOLD_CYC);
        pend_oe  <= 1'b0;
        if (active && bit_cnt == 4'd8) begin
          case (state)
            S_ADDR: begin
              if (shreg[7:1] == DEV_ADDR) begin
                addr_hit <= 1'b1;
                rw_bit   <= shreg[0];
                pend_oe  <= 1'b1;
              end else begin
                state <= S_IGN;
              end
            end
            S_IDX: begin
              reg_idx <= shreg;
              pend_oe <= 1'b1;
            end
            S_WD: begin
              reg_wdata <= shreg;
              pend_oe   <= 1'b1;
            end
            default: pend_oe <= 1'b0;
          endcase
        end else if (state == S_RD) begin
          pend_oe <= ~txreg[7];
          txreg   <= {txreg[6:0], 1'b0};
        end
      end
    end
  end

  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe);

  p_busy_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> bus_busy);

  p_busy_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !bus_busy);

  p_addr_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && state == S_ADDR && bit_cnt == 4'd8 && addr_hit) |-> sda_oe);

  p_ign_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IGN && $past(state) == S_IGN) |-> !reg_wr_stb);

  p_stb_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_stb |=> !reg_wr_stb);

  p_stb_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_stb |-> (scl_q && $past(state) == S_WD));

  p_sda_low_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!scl_q || $past(start_det || stop_det)));

endmodule

// File: tb/i2c_reg_slave_bench.sv
module i2c_reg_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QT = 4;
  localparam logic [6:0] ADDR = 7'b0011010;
  localparam int NV = 6;
  // {expect_ack, addr7, idx, data}
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 7'h1A, 8'h03, 8'h5C},
    {1'b1, 7'h1A, 8'h00, 8'hFF},
    {1'b0, 7'h1B, 8'h10, 8'h33},
    {1'b1, 7'h1A, 8'hFF, 8'h00},
    {1'b0, 7'h0D, 8'h03, 8'h99},
    {1'b1, 7'h1A, 8'h80, 8'hA5}
  };

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic sda_oe, bus_busy, reg_wr_stb;
  logic [7:0] reg_idx, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int errors = 0, checks = 0, stb_cnt = 0, pre_ack_stb = 0;
  int r9_bad = 0, since_fall = 0;
  logic prev_oe = 0, prev_scl = 1, done = 0;

  wire sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_slave u_i2c_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .bus_busy(bus_busy), .reg_wr_stb(reg_wr_stb),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_idx];
  always @(posedge clk) if (reg_wr_stb) mem[reg_idx] <= reg_wdata;

  always @(negedge clk) begin
    if (reg_wr_stb) stb_cnt++;
    if (prev_scl && !scl_m) since_fall = 0; else since_fall++;
    if (sda_oe != prev_oe && (scl_m || since_fall < 3)) r9_bad++;
    prev_oe  = sda_oe;
    prev_scl = scl_m;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_out(input logic b);
    wait_clk(QT); sda_m = b; wait_clk(2*QT);
    scl_m = 1; wait_clk(2*QT); scl_m = 0;
  endtask

  task automatic bus_start();
    sda_m = 1; scl_m = 1; wait_clk(2*QT);
    sda_m = 0; wait_clk(2*QT); scl_m = 0;
  endtask

  task automatic bus_rstart();
    wait_clk(QT); sda_m = 1; wait_clk(2*QT);
    scl_m = 1; wait_clk(2*QT); sda_m = 0; wait_clk(2*QT); scl_m = 0;
  endtask

  task automatic bus_stop();
    wait_clk(QT); sda_m = 0; wait_clk(2*QT);
    scl_m = 1; wait_clk(2*QT); sda_m = 1; wait_clk(2*QT);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    wait_clk(QT); sda_m = 1; pre_ack_stb = stb_cnt; wait_clk(2*QT);
    scl_m = 1; wait_clk(QT); ack = (sda_line == 1'b0); wait_clk(QT); scl_m = 0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wait_clk(QT); sda_m = 1; wait_clk(2*QT);
      scl_m = 1; wait_clk(QT); b[i] = sda_line; wait_clk(QT); scl_m = 0;
    end
    bit_out(!mack);
  endtask

  task automatic read_reg(input logic [7:0] idx, output logic [7:0] d);
    logic a;
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(idx, a);
    bus_rstart();
    send_byte({ADDR, 1'b1}, a);
    check(a, "R7 read address ack", a, 1);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    wait_clk(3);
    check(!sda_oe && !reg_wr_stb && !bus_busy && reg_idx == 0, "R10 reset state",
          {sda_oe, reg_wr_stb, bus_busy}, 0);
    rst_n = 1;
    wait_clk(4);

    for (int v = 0; v < NV; v++) begin
      logic ea, a;
      logic [6:0] ad;
      logic [7:0] ix, dt, rd;
      int s0;
      {ea, ad, ix, dt} = VEC[v];
      bus_start();
      check(bus_busy, "R1 busy after START", bus_busy, 1);
      send_byte({ad, 1'b0}, a);
      if (ea) begin
        check(a, "R2 address ack", a, 1);
        send_byte(ix, a);
        check(a && reg_idx == ix, "R4 index ack and value", reg_idx, ix);
        s0 = stb_cnt;
        send_byte(dt, a);
        check(a, "R4 data ack", a, 1);
        check(pre_ack_stb == s0, "R5 no strobe before ack rise", pre_ack_stb, s0);
        check(stb_cnt == s0 + 1, "R5 one strobe at ack rise", stb_cnt, s0 + 1);
        exp_mem[ix] = dt;
      end else begin
        check(!a, "R3 mismatch not acked", a, 0);
        s0 = stb_cnt;
        send_byte(ix, a);
        check(!a && !sda_oe, "R3 ignored byte not acked", a, 0);
        send_byte(dt, a);
        check(!a && stb_cnt == s0, "R3 no write after mismatch", stb_cnt, s0);
      end
      bus_stop();
      check(!bus_busy && !sda_oe, "R1 idle after STOP", bus_busy, 0);
      read_reg(ix, rd);
      check(rd == exp_mem[ix], "R7 readback", rd, exp_mem[ix]);
    end

    begin : extra_bytes
      logic a;
      logic [7:0] rd;
      int s0;
      s0 = stb_cnt;
      bus_start();
      send_byte({ADDR, 1'b0}, a);
      send_byte(8'h20, a);
      send_byte(8'hC3, a);
      send_byte(8'h3C, a);
      check(!a, "R6 byte after data not acked", a, 0);
      bus_stop();
      check(stb_cnt == s0 + 1, "R6 single strobe", stb_cnt, s0 + 1);
      exp_mem[8'h20] = 8'hC3;
      read_reg(8'h21, rd);
      check(rd == exp_mem[8'h21], "R6 next register untouched", rd, exp_mem[8'h21]);
      read_reg(8'h20, rd);
      check(rd == 8'hC3, "R6 data register written", rd, 8'hC3);
    end

    begin : multi_read
      logic a;
      logic [7:0] d0, d1;
      bus_start();
      send_byte({ADDR, 1'b0}, a);
      send_byte(8'h80, a);
      bus_rstart();
      send_byte({ADDR, 1'b1}, a);
      recv_byte(1'b1, d0);
      recv_byte(1'b0, d1);
      check(d0 == exp_mem[8'h80] && d1 == exp_mem[8'h80], "R8 repeated byte after ack",
            {d0, d1}, {exp_mem[8'h80], exp_mem[8'h80]});
      wait_clk(3*QT);
      check(!sda_oe, "R8 released after nack", sda_oe, 0);
      bus_stop();
    end

    begin : restart_cases
      logic a;
      logic [7:0] rd;
      bus_start();
      send_byte({ADDR, 1'b0}, a);
      send_byte(8'h40, a);
      bus_rstart();
      send_byte({ADDR, 1'b0}, a);
      send_byte(8'h41, a);
      send_byte(8'h77, a);
      bus_stop();
      exp_mem[8'h41] = 8'h77;
      read_reg(8'h40, rd);
      check(rd == exp_mem[8'h40], "R1 restart abandons first write", rd, exp_mem[8'h40]);
      read_reg(8'h41, rd);
      check(rd == 8'h77, "R1 restart write lands", rd, 8'h77);
      bus_start();
      send_byte({7'h55, 1'b0}, a);
      bus_rstart();
      send_byte({ADDR, 1'b0}, a);
      check(a, "R1 START leaves ignore state", a, 1);
      send_byte(8'h42, a);
      send_byte(8'h12, a);
      bus_stop();
      exp_mem[8'h42] = 8'h12;
      read_reg(8'h42, rd);
      check(rd == 8'h12, "R3 recovery after mismatch", rd, 8'h12);
      check(reg_idx == 8'h42, "R4 index kept after STOP", reg_idx, 8'h42);
    end

    check(r9_bad == 0, "R9 SDA drive changes only late in SCL low", r9_bad, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule